// File: doc/BRIEF.md
# Floating-Point Min/Max Selection Unit

This block picks the smaller or the larger of two IEEE 754 binary floating-point operands and returns it one clock after the operands are presented. One datapath serves sixteen operations: four comparison conventions, each with a minimum and a maximum form, and each of those with a variant that compares absolute values first. The conventions differ in how they treat NaN inputs and in whether negative zero orders below positive zero. They cover the 2008-style number-preferring selection, the 2019 NaN-propagating selection, the 2019 number-preferring selection, and the C ternary-expression selection.

Operands are 64-bit words. In single-precision mode only the low 32 bits carry the value and the result is zero-extended. Any signalling NaN input raises an invalid-operation flag alongside the result. Every NaN the unit returns is replaced by the canonical quiet NaN of the selected format, so downstream logic never sees an input payload.

A caller asserts `in_valid` together with the operands, format and operation code. The registered result, flag and `out_valid` appear on the following clock edge and hold until the next accepted operation.

Top module: `fp_minmax_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high; when `in_valid` is low, `result` and `invalid` keep their previous values on the next edge.
- R2: `op_sel` is decoded as bit 0 = maximum (1) or minimum (0), bits 2:1 = convention (0 = 2008 number-preferring, 1 = 2019 NaN-propagating, 2 = 2019 number-preferring, 3 = C ternary), bit 3 = magnitude variant.
- R3: Under both number-preferring conventions, if exactly one operand is NaN the other operand is returned, if both are NaN the canonical quiet NaN is returned, and -0 orders strictly below +0.
- R4: Under the NaN-propagating convention, any NaN operand gives the canonical quiet NaN, and -0 orders strictly below +0.
- R5: Under the C convention, minimum returns A when A < B and otherwise B; maximum returns A when A > B and otherwise B; unordered inputs and equal inputs (including -0 against +0) yield B.
- R6: A magnitude variant with no NaN operand returns A for minimum when |A| < |B| and B when |A| > |B|; for maximum the two tests are swapped.
- R7: A magnitude variant whose operands have equal magnitudes, or where either operand is NaN, returns what the plain operation of the same convention and direction returns on the signed operands.
- R8: Every NaN result is the canonical quiet NaN: 0x7FF8000000000000 in double precision, 0x7FC00000 in single precision.
- R9: `invalid` is 1 when either operand is a signalling NaN (exponent all ones, non-zero fraction, fraction MSB 0) and 0 otherwise, including for quiet NaN inputs.
- R10: With `fmt_dbl` = 0, operands are taken from bits 31:0, bits 63:32 of the operands are ignored, and bits 63:32 of `result` are zero.
- R11: After reset, `out_valid`, `result` and `invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision in bits 31:0 |
| op_sel | input | 4 | Operation code as described in R2 |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Selected operand or canonical quiet NaN |
| invalid | output | 1 | A signalling NaN was among the operands |

## Verification
The bench targets signed zeros under every convention: a design that compares raw magnitudes would return +0 for a 2008-style minimum of -0 and +0, while one that orders zeros in the C convention would stop returning B for the equal case. NaN cases cover a single quiet NaN, a signalling NaN, and NaN pairs in each convention; a wrong design would pass a payload through, propagate NaN in a number-preferring mode, or flag quiet NaNs as invalid. Magnitude ties and magnitude variants with a NaN operand check that the fallback follows the right plain convention rather than defaulting to B. Single-precision cases put garbage in the upper operand bits, which a design that leaked them would show in the result.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    localparam int unsigned WORD_W   = 64;
    localparam int unsigned SGL_W    = 32;
    localparam int unsigned DBL_EXP  = 11;
    localparam int unsigned DBL_FRAC = 52;
    localparam int unsigned SGL_EXP  = 8;
    localparam int unsigned SGL_FRAC = 23;
    localparam int unsigned MAG_W    = WORD_W - 1;

    // canonical quiet NaNs: exponent all ones, fraction MSB only
    localparam logic [WORD_W-1:0] DBL_QNAN =
        {1'b0, {DBL_EXP{1'b1}}, 1'b1, {(DBL_FRAC-1){1'b0}}};
    localparam logic [WORD_W-1:0] SGL_QNAN =
        {{(WORD_W-SGL_W){1'b0}}, 1'b0, {SGL_EXP{1'b1}}, 1'b1, {(SGL_FRAC-1){1'b0}}};

    typedef enum logic [1:0] {
        CONV_NUM08 = 2'd0,
        CONV_PROP19 = 2'd1,
        CONV_NUM19 = 2'd2,
        CONV_CTERN = 2'd3
    } conv_e;

    typedef struct packed {
        logic  by_mag;
        conv_e conv;
        logic  is_max;
    } op_t;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             nan;
        logic             snan;
        logic             zero;
    } opnd_info_t;

    typedef struct packed {
        logic              out_valid;
        logic              dbl;
        logic [WORD_W-1:0] result;
        logic              invalid;
    } unit_state_t;

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
    import fpmm_pkg::*;
(
    input  logic              fmt_dbl,
    input  logic [WORD_W-1:0] word,
    output opnd_info_t        info
);

    logic [DBL_EXP-1:0]  d_exp;
    logic [DBL_FRAC-1:0] d_frac;
    logic [SGL_EXP-1:0]  s_exp;
    logic [SGL_FRAC-1:0] s_frac;

    always_comb begin
        d_exp  = word[WORD_W-2 -: DBL_EXP];
        d_frac = word[DBL_FRAC-1:0];
        s_exp  = word[SGL_W-2 -: SGL_EXP];
        s_frac = word[SGL_FRAC-1:0];
        info   = '0;
        if (fmt_dbl) begin
            info.sign = word[WORD_W-1];
            info.mag  = word[MAG_W-1:0];
            info.nan  = (&d_exp) && (|d_frac);
            info.snan = info.nan && !d_frac[DBL_FRAC-1];
        end else begin
            info.sign = word[SGL_W-1];
            info.mag  = {{(WORD_W-SGL_W){1'b0}}, word[SGL_W-2:0]};
            info.nan  = (&s_exp) && (|s_frac);
            info.snan = info.nan && !s_frac[SGL_FRAC-1];
        end
        info.zero = (info.mag == '0);
    end

endmodule

// File: rtl/fpmm_decide.sv
module fpmm_decide
    import fpmm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  op_t        op,
    input  opnd_info_t a,
    input  opnd_info_t b,
    output logic       pick_b,
    output logic       make_qnan
);

    logic any_nan, both_nan;
    logic a_below, b_below;      // total order, -0 below +0
    logic a_lt_ieee, a_gt_ieee;  // ordered IEEE compare, zeros equal
    logic mag_lt, mag_gt;
    logic plain_pick_b, plain_qnan;

    // strict signed order in which -0 sits below +0
    function automatic logic below(input opnd_info_t x, input opnd_info_t y);
        if (x.sign != y.sign) return x.sign;
        if (x.sign)           return x.mag > y.mag;
        return x.mag < y.mag;
    endfunction

    always_comb begin
        any_nan   = a.nan || b.nan;
        both_nan  = a.nan && b.nan;
        a_below   = below(a, b);
        b_below   = below(b, a);
        a_lt_ieee = !any_nan && !(a.zero && b.zero) && a_below;
        a_gt_ieee = !any_nan && !(a.zero && b.zero) && b_below;
        mag_lt    = a.mag < b.mag;
        mag_gt    = a.mag > b.mag;

        plain_qnan   = 1'b0;
        plain_pick_b = 1'b1;
        unique case (op.conv)
            CONV_NUM08, CONV_NUM19: begin
                if (both_nan)    plain_qnan   = 1'b1;
                else if (a.nan)  plain_pick_b = 1'b1;
                else if (b.nan)  plain_pick_b = 1'b0;
                else             plain_pick_b = op.is_max ? !b_below : !a_below;
            end
            CONV_PROP19: begin
                if (any_nan) plain_qnan   = 1'b1;
                else         plain_pick_b = op.is_max ? !b_below : !a_below;
            end
            CONV_CTERN: begin
                plain_pick_b = op.is_max ? !a_gt_ieee : !a_lt_ieee;
            end
            default: plain_pick_b = 1'b1;
        endcase

        pick_b    = plain_pick_b;
        make_qnan = plain_qnan;
        if (op.by_mag && !any_nan && (mag_lt || mag_gt)) begin
            make_qnan = 1'b0;
            pick_b    = op.is_max ? mag_lt : mag_gt;
        end
    end

    // R6: strict magnitude order decides a magnitude minimum
    p_mag_min_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && op.by_mag && !op.is_max && !a.nan && !b.nan && (a.mag < b.mag))
            |-> (!pick_b && !make_qnan));

    // R3: two NaNs under a number-preferring convention give a quiet NaN
    p_both_nan_qnan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && a.nan && b.nan && (op.conv == CONV_NUM08 || op.conv == CONV_NUM19))
            |-> make_qnan);

endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
    import fpmm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              fmt_dbl,
    input  logic [3:0]        op_sel,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              invalid
);

    localparam int unsigned N_OPND = 2;

    logic [WORD_W-1:0] opnd_word [N_OPND];
    opnd_info_t        opnd_info [N_OPND];
    op_t               op;
    logic              pick_b, make_qnan;
    unit_state_t       state_d, state_q;

    assign opnd_word[0] = opa;
    assign opnd_word[1] = opb;
    assign op           = op_t'(op_sel);

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
        fpmm_classify u_cls (
            .fmt_dbl (fmt_dbl),
            .word    (opnd_word[gi]),
            .info    (opnd_info[gi])
        );
    end

    fpmm_decide u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (in_valid),
        .op        (op),
        .a         (opnd_info[0]),
        .b         (opnd_info[1]),
        .pick_b    (pick_b),
        .make_qnan (make_qnan)
    );

    logic [WORD_W-1:0] chosen;
    logic              chosen_nan;
    logic [WORD_W-1:0] fmt_mask;

    always_comb begin
        chosen     = pick_b ? opb : opa;
        chosen_nan = pick_b ? opnd_info[1].nan : opnd_info[0].nan;
        fmt_mask   = fmt_dbl ? '1 : {{(WORD_W-SGL_W){1'b0}}, {SGL_W{1'b1}}};

        state_d           = state_q;
        state_d.out_valid = in_valid;
        if (in_valid) begin
            state_d.dbl     = fmt_dbl;
            state_d.invalid = opnd_info[0].snan || opnd_info[1].snan;
            if (make_qnan || chosen_nan)
                state_d.result = fmt_dbl ? DBL_QNAN : SGL_QNAN;
            else
                state_d.result = chosen & fmt_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.out_valid;
    assign result    = state_q.result;
    assign invalid   = state_q.invalid;

    // R1: one-cycle handshake and hold between operations
    p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(invalid)));

    // R10: single-precision results are zero-extended
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !state_q.dbl) |-> (result[WORD_W-1:SGL_W] == '0));

    // R8: a double NaN result carries only the canonical fraction
    p_canon_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && state_q.dbl && (&result[WORD_W-2 -: DBL_EXP]) && (|result[DBL_FRAC-1:0]))
            |-> (result == DBL_QNAN));

    // R4: NaN-propagating plain operation with a NaN input yields the quiet NaN
    p_prop_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op.by_mag && op.conv == CONV_PROP19 && (opnd_info[0].nan || opnd_info[1].nan))
            |=> (result == (state_q.dbl ? DBL_QNAN : SGL_QNAN)));

    // R9: signalling NaN input raises the flag
    p_snan_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opnd_info[0].snan || opnd_info[1].snan)) |=> invalid);

endmodule

// File: tb/tb_fp_minmax_unit.sv
`timescale 1ns/1ps
module tb_fp_minmax_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        fmt_dbl = 1'b1;
    logic [3:0]  op_sel = '0;
    logic [63:0] opa = '0, opb = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fp_minmax_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
        .op_sel(op_sel), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result), .invalid(invalid)
    );

    // double constants
    localparam logic [63:0] D_P1  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_N1  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] D_P2  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_N2  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] D_PZ  = 64'h0000_0000_0000_0000;
    localparam logic [63:0] D_NZ  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] D_QN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D_QNP = 64'hFFF8_0000_0000_0123;
    localparam logic [63:0] D_SN  = 64'h7FF4_0000_0000_0000;
    // single constants, upper half as given
    localparam logic [63:0] S_P1G = 64'hDEAD_BEEF_3F80_0000;
    localparam logic [63:0] S_P2G = 64'h1234_5678_4000_0000;
    localparam logic [63:0] S_P1  = 64'h0000_0000_3F80_0000;
    localparam logic [63:0] S_P2  = 64'h0000_0000_4000_0000;
    localparam logic [63:0] S_N2  = 64'h0000_0000_C000_0000;
    localparam logic [63:0] S_PZ  = 64'h0000_0000_0000_0000;
    localparam logic [63:0] S_NZ  = 64'h0000_0000_8000_0000;
    localparam logic [63:0] S_QN  = 64'h0000_0000_7FC0_0000;
    localparam logic [63:0] S_SNG = 64'hFFFF_FFFF_7F80_0001;

    // op_sel = {magnitude, convention[1:0], max}
    typedef struct packed {
        logic        dbl;
        logic [3:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        inv;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd0,  D_P1,  D_P2,  D_P1,  1'b0, "R2 "},  // 2008 min
        '{1'b1, 4'd1,  D_P1,  D_P2,  D_P2,  1'b0, "R2 "},  // 2008 max
        '{1'b1, 4'd0,  D_NZ,  D_PZ,  D_NZ,  1'b0, "R3 "},
        '{1'b1, 4'd1,  D_NZ,  D_PZ,  D_PZ,  1'b0, "R3 "},
        '{1'b1, 4'd0,  D_QNP, D_P2,  D_P2,  1'b0, "R3 "},
        '{1'b1, 4'd1,  D_SN,  D_P2,  D_P2,  1'b1, "R9 "},
        '{1'b1, 4'd0,  D_QNP, D_SN,  D_QN,  1'b1, "R3 "},
        '{1'b1, 4'd4,  D_P1,  D_QNP, D_P1,  1'b0, "R3 "},  // 2019 number min
        '{1'b1, 4'd5,  D_N2,  D_N1,  D_N1,  1'b0, "R3 "},
        '{1'b1, 4'd2,  D_QNP, D_P1,  D_QN,  1'b0, "R4 "},  // 2019 propagating min
        '{1'b1, 4'd3,  D_NZ,  D_PZ,  D_PZ,  1'b0, "R4 "},
        '{1'b1, 4'd2,  D_PZ,  D_NZ,  D_NZ,  1'b0, "R4 "},
        '{1'b1, 4'd6,  D_NZ,  D_PZ,  D_PZ,  1'b0, "R5 "},  // C min, equal -> B
        '{1'b1, 4'd7,  D_PZ,  D_NZ,  D_NZ,  1'b0, "R5 "},
        '{1'b1, 4'd6,  D_QNP, D_P1,  D_P1,  1'b0, "R5 "},
        '{1'b1, 4'd6,  D_P1,  D_QNP, D_QN,  1'b0, "R8 "},
        '{1'b1, 4'd7,  D_P2,  D_P1,  D_P2,  1'b0, "R5 "},
        '{1'b1, 4'd8,  D_N1,  D_P2,  D_N1,  1'b0, "R6 "},  // magnitude 2008 min
        '{1'b1, 4'd9,  D_N2,  D_P1,  D_N2,  1'b0, "R6 "},
        '{1'b1, 4'd8,  D_N1,  D_P1,  D_N1,  1'b0, "R7 "},
        '{1'b1, 4'd9,  D_N1,  D_P1,  D_P1,  1'b0, "R7 "},
        '{1'b1, 4'd8,  D_QNP, D_N2,  D_N2,  1'b0, "R7 "},
        '{1'b1, 4'd10, D_N2,  D_QNP, D_QN,  1'b0, "R7 "},
        '{1'b1, 4'd14, D_P1,  D_N1,  D_N1,  1'b0, "R7 "},
        '{1'b0, 4'd0,  S_P1G, S_P2G, S_P1,  1'b0, "R10"},
        '{1'b0, 4'd3,  S_SNG, S_P1,  S_QN,  1'b1, "R8 "},
        '{1'b0, 4'd9,  S_N2,  S_P1,  S_N2,  1'b0, "R6 "},
        '{1'b0, 4'd0,  S_NZ,  S_PZ,  S_NZ,  1'b0, "R3 "},
        '{1'b0, 4'd7,  S_P2G, S_P1,  S_P2,  1'b0, "R10"},
        '{1'b1, 4'd1,  D_P1,  D_N2,  D_P1,  1'b0, "R2 "}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic dbl, input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        fmt_dbl  = dbl;
        op_sel   = op;
        opa      = a;
        opb      = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 out_valid", {63'b0, out_valid}, 64'd0);
        check("R11 result", result, 64'd0);
        check("R11 invalid", {63'b0, invalid}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].dbl, VECS[i].op, VECS[i].a, VECS[i].b);
            check({string'(VECS[i].tag), " valid"}, {63'b0, out_valid}, 64'd1);
            check({string'(VECS[i].tag), " result"}, result, VECS[i].exp);
            check({string'(VECS[i].tag), " invalid"}, {63'b0, invalid}, {63'b0, VECS[i].inv});
        end

        // R1: idle cycle with changed inputs leaves outputs held
        issue(1'b1, 4'd1, D_SN, D_P2);
        @(negedge clk);
        fmt_dbl = 1'b1; op_sel = 4'd0; opa = D_N2; opb = D_QNP;
        @(negedge clk);
        check("R1 idle valid", {63'b0, out_valid}, 64'd0);
        check("R1 held result", result, D_P2);
        check("R1 held invalid", {63'b0, invalid}, 64'd1);

        // R1: back-to-back operations each one cycle later
        @(negedge clk);
        op_sel = 4'd0; opa = D_P2; opb = D_N1; in_valid = 1'b1;
        @(negedge clk);
        check("R1 b2b first", result, D_N1);
        op_sel = 4'd1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 b2b second", result, D_P2);
        check("R1 b2b valid", {63'b0, out_valid}, 64'd1);
        @(negedge clk);
        check("R1 b2b drop", {63'b0, out_valid}, 64'd0);

        // R9: quiet NaN alone does not flag
        issue(1'b0, 4'd2, S_QN, S_P1);
        check("R9 qnan noflag", {63'b0, invalid}, 64'd0);
        check("R8 single canon", result, S_QN);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule